// File: doc/BRIEF.md
# Data-Processing ALU with Flag Update

This block is the arithmetic and logic stage of a 32-bit RISC core. Each cycle it can accept one data-processing instruction word together with the first operand, the already-shifted second register operand with its shifter carry-out, and the current condition flags. One clock later it presents the computed value, a write-enable for the destination register and the next N/Z/C/V flags.

The 4-bit operation field selects among bitwise, add/subtract-family and compare/test operations. When the immediate-select bit is set, the block builds the second operand itself by rotating an 8-bit constant. The set-flags bit controls whether the flags change at all. Writing the program-counter slot with set-flags does not update the flags. Instead the block raises a restore request for the surrounding core to copy the saved status. Register access and the status restore itself are done elsewhere.

Top module: `dpu_alu`

## Requirements
- R1: The operation field is instruction bits [24:21]. Codes 0 AND, 1 EOR, 12 ORR, 13 MOV (operand 2), 14 BIC (a AND NOT b), 15 MVN (NOT operand 2), 8 TST (AND) and 9 TEQ (EOR) produce the named bitwise value on `res_data`.
- R2: Codes 2 SUB (a-b), 3 RSB (b-a), 4 ADD, 5 ADC (a+b+C), 6 SBC (a-b-NOT C), 7 RSC (b-a-NOT C), 10 CMP (a-b) and 11 CMN (a+b) produce their 32-bit modular value on `res_data`, where C is `flags_in[1]`.
- R3: Codes 8 to 11 never assert `res_we`. Every other code asserts it on its result cycle.
- R4: When flags are updated, N (`flags_out[3]`) equals result bit 31 and Z (`flags_out[2]`) is set exactly when the 32-bit result is zero.
- R5: For codes 2–7 and 10–11 with a flag update, C (`flags_out[1]`) is the carry out of an addition or the not-borrow of a subtraction. V (`flags_out[0]`) is the signed overflow of that operation.
- R6: For the bitwise codes with a flag update, C takes the shifter carry-out and V keeps `flags_in[0]`.
- R7: With instruction bit 25 set, operand 2 is bits [7:0] rotated right by twice bits [11:8], and the shifter carry-out used is the incoming C flag instead of `shift_carry`.
- R8: With instruction bit 20 clear, `flags_out` equals `flags_in`.
- R9: With bit 20 set, destination field [15:12] equal to 15 and a code outside 8–11, `restore_req` is asserted and `flags_out` equals `flags_in`. Otherwise `restore_req` is low.
- R10: Outputs appear exactly one clock after `op_valid`. In a cycle following no valid input, `res_valid`, `res_we` and `restore_req` are low.
- R11: A synchronous active-low reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Data-processing instruction word |
| opnd_a | input | 32 | First operand |
| shift_val | input | 32 | Shifted second register operand |
| shift_carry | input | 1 | Shifter carry-out for `shift_val` |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| res_valid | output | 1 | Result cycle marker |
| res_data | output | 32 | Computed value (also for compare/test) |
| res_we | output | 1 | Destination register write enable |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| restore_req | output | 1 | Request to restore status from the saved copy |

## Verification
The hardest cases to reach are the carry-in operations at their boundaries. Examples are SBC and RSC with C clear that turn an equal pair into a borrow, ADC wrapping from all-ones, and signed overflow across the 0x7FFFFFFF/0x80000000 edge. Directed vectors place operands exactly there with both values of the incoming C flag. A long random run, with the destination field forced to 15 on a share of instructions, covers the restore path. Immediate rotations and idle gaps are mixed in, so the cycle after a bubble is also compared.

// File: rtl/dpu_pkg.sv
// Shared types and field positions for the data-processing ALU.
// Assumes a 32-bit instruction word with fixed field positions.
package dpu_pkg;

    localparam int INSTR_W  = 32;
    localparam int OPC_LSB  = 21;
    localparam int OPC_W    = 4;
    localparam int SETF_BIT = 20;
    localparam int IMMS_BIT = 25;
    localparam int DST_LSB  = 12;
    localparam int DST_W    = 4;
    localparam int IMM_W    = 8;
    localparam int ROT_LSB  = 8;
    localparam int ROT_W    = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } dp_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } dp_flags_t;

    // True for the add/subtract family (flags take arithmetic C and V).
    function automatic logic op_is_arith(input dp_op_e op);
        return (op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN});
    endfunction

    // True for compare/test codes, which never write the destination.
    function automatic logic op_is_cmp(input dp_op_e op);
        return (op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN});
    endfunction

endpackage

// File: rtl/dpu_imm_rot.sv
// Immediate operand builder: zero-extends an IMM_W constant and rotates it
// right by twice the ROT_W rotate field, one conditional stage per bit.
// Assumes 2 << (ROT_W-1) is smaller than DATA_W.
module dpu_imm_rot #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic [ROT_W-1:0]  rot,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] stage [ROT_W+1];

    assign stage[0] = {{(DATA_W-IMM_W){1'b0}}, imm};

    for (genvar k = 0; k < ROT_W; k++) begin : g_stage
        localparam int AMT = 2 << k;
        // Each stage rotates by 2^(k+1) when its rotate bit is set.
        assign stage[k+1] = rot[k] ? {stage[k][AMT-1:0], stage[k][DATA_W-1:AMT]}
                                   : stage[k];
    end

    assign value = stage[ROT_W];
endmodule

// File: rtl/dpu_addsub.sv
// Shared adder for the arithmetic codes: sum = x + (inv_y ? ~y : y) + cin.
// Carry is the adder carry-out (not-borrow for subtraction); overflow is
// the two's-complement overflow of the same addition.
module dpu_addsub #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              inv_y,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              carry,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;
    logic [DATA_W-1:0] y_eff;

    // One wide add produces both the sum and its carry-out.
    always_comb begin
        y_eff          = inv_y ? ~y : y;
        {carry, sum}   = {1'b0, x} + {1'b0, y_eff} + {{DATA_W{1'b0}}, cin};
        ovf            = (x[MSB] == y_eff[MSB]) && (sum[MSB] != x[MSB]);
    end
endmodule

// File: rtl/dpu_logic.sv
// Bitwise unit for the non-arithmetic codes; arithmetic codes give zero.
module dpu_logic #(
    parameter int DATA_W = 32
) (
    input  dpu_pkg::dp_op_e   op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    import dpu_pkg::*;

    // Select the bitwise function named by the operation code.
    always_comb begin
        unique case (op)
            OP_AND, OP_TST: y = a & b;
            OP_EOR, OP_TEQ: y = a ^ b;
            OP_ORR:         y = a | b;
            OP_MOV:         y = b;
            OP_BIC:         y = a & ~b;
            OP_MVN:         y = ~b;
            default:        y = '0;
        endcase
    end
endmodule

// File: rtl/dpu_alu.sv
// Data-processing ALU top: operand-2 selection, add/sub and bitwise units,
// flag rules by operation class and status-restore detection, registered
// with one cycle of latency. Assumes flags are ordered {N,Z,C,V}.
module dpu_alu #(
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         op_valid,
    input  logic [dpu_pkg::INSTR_W-1:0]  instr,
    input  logic [DATA_W-1:0]            opnd_a,
    input  logic [DATA_W-1:0]            shift_val,
    input  logic                         shift_carry,
    input  logic [3:0]                   flags_in,
    output logic                         res_valid,
    output logic [DATA_W-1:0]            res_data,
    output logic                         res_we,
    output logic [3:0]                   flags_out,
    output logic                         restore_req
);
    import dpu_pkg::*;

    localparam int MSB = DATA_W - 1;

    dp_op_e            op;
    dp_flags_t         fin, fnext;
    logic              set_f, imm_sel, dst_pc, is_arith, is_cmp, do_restore;
    logic [DATA_W-1:0] imm_val, op2, ax, ay, sum, lval, value;
    logic              sh_c, inv_y, cin, a_carry, a_ovf;
    logic              unused_fields;

    assign unused_fields = ^{instr[INSTR_W-1:IMMS_BIT+1], instr[DST_LSB+DST_W+3:DST_LSB+DST_W]};

    assign op       = dp_op_e'(instr[OPC_LSB +: OPC_W]);
    assign set_f    = instr[SETF_BIT];
    assign imm_sel  = instr[IMMS_BIT];
    assign dst_pc   = &instr[DST_LSB +: DST_W];
    assign fin      = dp_flags_t'(flags_in);
    assign is_arith = op_is_arith(op);
    assign is_cmp   = op_is_cmp(op);

    dpu_imm_rot #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rot (
        .imm   (instr[IMM_W-1:0]),
        .rot   (instr[ROT_LSB +: ROT_W]),
        .value (imm_val)
    );

    // Operand 2 and its carry come from the rotator or the external shifter.
    always_comb begin
        op2  = imm_sel ? imm_val : shift_val;
        sh_c = imm_sel ? fin.c   : shift_carry;
    end

    // Map each arithmetic code onto the shared adder's operands and carry-in.
    always_comb begin
        ax = opnd_a; ay = op2; inv_y = 1'b0; cin = 1'b0;
        unique case (op)
            OP_SUB, OP_CMP: begin inv_y = 1'b1; cin = 1'b1; end
            OP_RSB:         begin ax = op2; ay = opnd_a; inv_y = 1'b1; cin = 1'b1; end
            OP_ADC:         cin = fin.c;
            OP_SBC:         begin inv_y = 1'b1; cin = fin.c; end
            OP_RSC:         begin ax = op2; ay = opnd_a; inv_y = 1'b1; cin = fin.c; end
            default:        ;
        endcase
    end

    dpu_addsub #(.DATA_W(DATA_W)) u_add (
        .x(ax), .y(ay), .inv_y(inv_y), .cin(cin),
        .sum(sum), .carry(a_carry), .ovf(a_ovf)
    );

    dpu_logic #(.DATA_W(DATA_W)) u_log (
        .op(op), .a(opnd_a), .b(op2), .y(lval)
    );

    // Pick the value and build the next flags by operation class.
    always_comb begin
        value      = is_arith ? sum : lval;
        do_restore = set_f && dst_pc && !is_cmp;
        fnext      = fin;
        if (set_f && !do_restore) begin
            fnext.n = value[MSB];
            fnext.z = (value == '0);
            fnext.c = is_arith ? a_carry : sh_c;
            fnext.v = is_arith ? a_ovf   : fin.v;
        end
    end

    // Result register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_data    <= '0;
            res_we      <= 1'b0;
            flags_out   <= '0;
            restore_req <= 1'b0;
        end else begin
            res_valid   <= op_valid;
            res_we      <= op_valid && !is_cmp;
            restore_req <= op_valid && do_restore;
            if (op_valid) begin
                res_data  <= value;
                flags_out <= fnext;
            end
        end
    end

    // Compare/test codes must not produce a register write.
    assert_cmp_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && instr[24:23] == 2'b10) |=> !res_we);

    // Without set-flags the flags pass through unchanged.
    assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !instr[SETF_BIT]) |=> (flags_out == $past(flags_in)));

    // N and Z follow the presented value whenever flags are updated.
    assert_nz_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && instr[SETF_BIT] && !(dst_pc && !is_cmp))
        |=> (flags_out[3] == res_data[MSB] && flags_out[2] == (res_data == '0)));

    // Bitwise codes keep V when flags are updated.
    assert_logic_keeps_v_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && instr[SETF_BIT] && !is_arith && !dst_pc)
        |=> (flags_out[0] == $past(flags_in[0])));

    // Restore request replaces the flag update.
    assert_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && instr[SETF_BIT] && dst_pc && !is_cmp)
        |=> (restore_req && flags_out == $past(flags_in)));

    // An idle cycle yields no valid, no write and no restore.
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !res_we && !restore_req));

    // Write and restore only accompany a valid result.
    assert_strobes_need_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we || restore_req) |-> res_valid);
endmodule

// File: tb/dpu_alu_tb.sv
module dpu_alu_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [31:0] instr, opnd_a, shift_val;
    logic        shift_carry;
    logic [3:0]  flags_in;
    logic        res_valid, res_we, restore_req;
    logic [31:0] res_data;
    logic [3:0]  flags_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Expected values from the behavioural model.
    logic        e_valid, e_we, e_rst;
    logic [31:0] e_data;
    logic [3:0]  e_flags;
    string       t_val, t_flag_nz, t_flag_cv;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpu_alu dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .instr(instr),
        .opnd_a(opnd_a), .shift_val(shift_val), .shift_carry(shift_carry),
        .flags_in(flags_in), .res_valid(res_valid), .res_data(res_data),
        .res_we(res_we), .flags_out(flags_out), .restore_req(restore_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: computes expected outputs from one input set.
    task automatic model(input logic v, input logic [31:0] ins, input logic [31:0] a,
                         input logic [31:0] sv, input logic sc, input logic [3:0] fl);
        int          op;
        int          rot;
        logic [31:0] b, imm, val;
        logic        c, vv, arith, cmp, restore, sub_t;
        longint unsigned ux, uy, tot;
        longint      sx, sy, s;
        int          extra;
        op    = int'(ins[24:21]);
        cmp   = (op >= 8 && op <= 11);
        arith = (op >= 2 && op <= 7) || op == 10 || op == 11;
        if (ins[25]) begin
            rot = int'(ins[11:8]) * 2;
            imm = {24'd0, ins[7:0]};
            b   = (imm >> rot) | (imm << (32 - rot));
            sc  = fl[1];
        end else b = sv;
        c = sc; vv = fl[0]; val = 0;
        t_val = ins[25] ? "R7" : (arith ? "R2" : "R1");
        if (arith) begin
            ux = (op == 3 || op == 7) ? longint'(b) : longint'(a);
            uy = (op == 3 || op == 7) ? longint'(a) : longint'(b);
            sx = longint'($signed(ux[31:0]));
            sy = longint'($signed(uy[31:0]));
            sub_t = !(op == 4 || op == 5 || op == 11);
            if (op == 5)                extra = fl[1] ? 1 : 0;
            else if (op == 6 || op == 7) extra = fl[1] ? 0 : 1;
            else                        extra = 0;
            if (sub_t) begin
                tot = ux - uy - longint'(extra);
                c   = (ux >= uy + longint'(extra));
                s   = sx - sy - longint'(extra);
            end else begin
                tot = ux + uy + longint'(extra);
                c   = tot[32];
                s   = sx + sy + longint'(extra);
            end
            val = tot[31:0];
            vv  = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        end else begin
            case (op)
                0, 8:    val = a & b;
                1, 9:    val = a ^ b;
                12:      val = a | b;
                13:      val = b;
                14:      val = a & ~b;
                default: val = ~b;
            endcase
        end
        restore   = ins[20] && ins[15:12] == 4'hF && !cmp;
        t_flag_nz = "R8";
        t_flag_cv = "R8";
        if (v) begin
            e_valid = 1'b1;
            e_we    = !cmp;
            e_rst   = restore;
            e_data  = val;
            if (restore) begin
                e_flags = fl; t_flag_nz = "R9"; t_flag_cv = "R9";
            end else if (ins[20]) begin
                e_flags   = {val[31], val == 0, c, vv};
                t_flag_nz = "R4";
                t_flag_cv = arith ? "R5" : (ins[25] ? "R7" : "R6");
            end else e_flags = fl;
        end else begin
            e_valid = 1'b0; e_we = 1'b0; e_rst = 1'b0;
        end
    endtask

    // Drive one cycle of input, then compare one clock later off the edge.
    task automatic step(input logic v, input logic [31:0] ins, input logic [31:0] a,
                        input logic [31:0] sv, input logic sc, input logic [3:0] fl);
        op_valid = v; instr = ins; opnd_a = a; shift_val = sv;
        shift_carry = sc; flags_in = fl;
        model(v, ins, a, sv, sc, fl);
        @(posedge clk);
        @(negedge clk);
        chk("R10 valid", {31'd0, res_valid}, {31'd0, e_valid});
        chk(ins[24:23] == 2'b10 ? "R3 we" : "R3 we", {31'd0, res_we}, {31'd0, e_we});
        chk("R9 restore", {31'd0, restore_req}, {31'd0, e_rst});
        if (v) begin
            chk(t_val, res_data, e_data);
            chk({t_flag_nz, " NZ"}, {30'd0, flags_out[3:2]}, {30'd0, e_flags[3:2]});
            chk({t_flag_cv, " CV"}, {30'd0, flags_out[1:0]}, {30'd0, e_flags[1:0]});
        end else begin
            // Held values stay as they were (R10).
            chk("R10 hold data", res_data, e_data);
            chk("R10 hold flags", {28'd0, flags_out}, {28'd0, e_flags});
        end
    endtask

    function automatic logic [31:0] mk(input int op, input bit s, input bit imm,
                                       input logic [3:0] rd, input logic [11:0] lo);
        return {6'b111000, imm, 4'(op), s, 4'h1, rd, lo};
    endfunction

    task automatic check_reset(input string tag);
        chk({tag, " valid"}, {31'd0, res_valid}, 32'd0);
        chk({tag, " data"}, res_data, 32'd0);
        chk({tag, " we"}, {31'd0, res_we}, 32'd0);
        chk({tag, " flags"}, {28'd0, flags_out}, 32'd0);
        chk({tag, " restore"}, {31'd0, restore_req}, 32'd0);
        e_data = 0; e_flags = 0;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        rst_n = 1'b0; op_valid = 1'b1; instr = 32'hFFFF_FFFF;
        opnd_a = 32'hFFFF_FFFF; shift_val = 32'hFFFF_FFFF;
        shift_carry = 1'b1; flags_in = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset("R11 reset");
        rst_n = 1'b1;

        // R1 bitwise codes, register operand, flags on
        step(1, mk(0, 1, 0, 4'h2, 12'h0), 32'hF0F0_1234, 32'h0FF0_FFFF, 1'b1, 4'b0001);
        step(1, mk(1, 1, 0, 4'h2, 12'h0), 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0, 4'b1110);
        step(1, mk(12, 0, 0, 4'h2, 12'h0), 32'h1200_0000, 32'h0000_0034, 1'b1, 4'b0000);
        step(1, mk(13, 1, 0, 4'h2, 12'h0), 32'h0, 32'h8000_0000, 1'b1, 4'b0000);
        step(1, mk(14, 1, 0, 4'h2, 12'h0), 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0, 4'b0101);
        step(1, mk(15, 1, 0, 4'h2, 12'h0), 32'h0, 32'hFFFF_FFFF, 1'b1, 4'b1001);
        // R2/R5 arithmetic edges
        step(1, mk(4, 1, 0, 4'h3, 12'h0), 32'h7FFF_FFFF, 32'h1, 1'b0, 4'b0000);
        step(1, mk(2, 1, 0, 4'h3, 12'h0), 32'h0, 32'h1, 1'b0, 4'b0000);
        step(1, mk(2, 1, 0, 4'h3, 12'h0), 32'h5, 32'h5, 1'b0, 4'b0000);
        step(1, mk(6, 1, 0, 4'h3, 12'h0), 32'h5, 32'h5, 1'b0, 4'b0000);
        step(1, mk(6, 1, 0, 4'h3, 12'h0), 32'h5, 32'h5, 1'b0, 4'b0010);
        step(1, mk(7, 1, 0, 4'h3, 12'h0), 32'h8, 32'h8, 1'b0, 4'b0000);
        step(1, mk(3, 1, 0, 4'h3, 12'h0), 32'h8000_0000, 32'h1, 1'b0, 4'b0000);
        step(1, mk(5, 1, 0, 4'h3, 12'h0), 32'hFFFF_FFFF, 32'h0, 1'b0, 4'b0010);
        step(1, mk(5, 1, 0, 4'h3, 12'h0), 32'h8000_0000, 32'h8000_0000, 1'b0, 4'b0000);
        // R3 compare/test, including destination 15
        step(1, mk(10, 1, 0, 4'hF, 12'h0), 32'h3, 32'h7, 1'b0, 4'b0000);
        step(1, mk(11, 1, 0, 4'h0, 12'h0), 32'hFFFF_FFFF, 32'h1, 1'b0, 4'b0000);
        step(1, mk(8, 1, 0, 4'h0, 12'h0), 32'hF0, 32'h0F, 1'b1, 4'b0001);
        step(1, mk(9, 0, 0, 4'h0, 12'h0), 32'h1, 32'h1, 1'b1, 4'b1010);
        // R7 immediate rotation, incoming C feeds shifter carry
        step(1, mk(13, 1, 1, 4'h4, 12'h1FF), 32'h0, 32'h0, 1'b0, 4'b0010);
        step(1, mk(13, 1, 1, 4'h4, 12'h0AB), 32'h0, 32'hDEAD_BEEF, 1'b1, 4'b0000);
        step(1, mk(4, 1, 1, 4'h4, 12'hF01), 32'h10, 32'h0, 1'b0, 4'b0000);
        // R8 no set-flags, R9 restore
        step(1, mk(2, 0, 0, 4'h5, 12'h0), 32'h0, 32'h1, 1'b0, 4'b0101);
        step(1, mk(4, 1, 0, 4'hF, 12'h0), 32'hFFFF_FFFF, 32'h1, 1'b0, 4'b0110);
        step(1, mk(13, 1, 0, 4'hF, 12'h0), 32'h0, 32'h0, 1'b1, 4'b1001);
        // R10 idle cycles
        step(0, mk(4, 1, 0, 4'h1, 12'h0), 32'h1, 32'h1, 1'b0, 4'b0000);
        step(0, mk(11, 1, 0, 4'hF, 12'h0), 32'h1, 32'h1, 1'b1, 4'b1111);

        // Random mix with a share of destination-15 and idle cycles
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ins;
            logic [31:0] ra, rb;
            ins = $urandom;
            if ($urandom_range(0, 3) == 0) ins[15:12] = 4'hF;
            ra = ($urandom_range(0, 7) == 0) ? 32'h7FFF_FFFF : 32'($urandom);
            rb = ($urandom_range(0, 7) == 0) ? 32'h8000_0000 : 32'($urandom);
            step($urandom_range(0, 9) != 0, ins, ra, rb, 1'($urandom), 4'($urandom));
        end

        // R11 reset mid-stream
        rst_n = 1'b0; op_valid = 1'b1; instr = mk(4, 1, 0, 4'hF, 12'h0);
        @(posedge clk);
        @(negedge clk);
        check_reset("R11 midreset");
        rst_n = 1'b1;
        step(1, mk(2, 1, 0, 4'h1, 12'h0), 32'h2, 32'h3, 1'b0, 4'b0000);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule